// File: doc/BRIEF.md
# Configurable Jump-and-Save Unit

This block executes a single jump instruction whose 5-bit configuration field selects a set of independent side effects. The new program counter is either the 18-bit operand address or that address plus the contents of a selected index register. The same instruction can also do any mix of the following: store the current program counter (P) in the selected index register, place P in the right half or the second address register (Q) in the left half of the 36-bit exchange register (E), and ask for the running sequence to be dismissed. An operand whose defer bit is set is not supported. Such an instruction produces an alarm and has no other effect.

The instruction comes in over a valid/ready handshake. The caller presents the decoded fields, the current P, Q and E values, and the read data of the index register that the 6-bit select names. The unit accepts an instruction on a clock edge where `in_valid` and `in_ready` are both high. One cycle later it holds the complete result in an output register and raises `res_valid`. All write enables and data in that result belong to the same instruction, so the surrounding core commits them together. The result is consumed on an edge where `res_valid` and `res_ready` are both high. If `res_ready` is low, the result stays frozen. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives full throughput when the consumer never stalls.

Top module: `jump_save_unit`

## Requirements
- R1: When configuration bit 0 (value 1) is clear, `res_pc` equals the operand address.
- R2: When configuration bit 0 is set, `res_pc` is the operand address plus the index read data, taken as an 18-bit two's-complement value and wrapped modulo 2^18. The index value used is the one read before this instruction's own index write.
- R3: Configuration bit 1 (value 2) produces an index write of P to the selected register (`res_xr_we`=1, `res_xr_data`=P, `res_xr_sel`=select). This happens only when the select is nonzero. Register 0 is never written.
- R4: Configuration bit 2 (value 4) makes bits 17:0 of `res_e` equal P. Otherwise those bits equal the incoming E bits 17:0.
- R5: Configuration bit 3 (value 8) makes bits 35:18 of `res_e` equal Q. Otherwise those bits equal the incoming E bits 35:18. `res_e_we` is 1 exactly when bit 2 or bit 3 is set.
- R6: Configuration bit 4 (value 16) sets `res_dismiss`, unless the hold input is set. In that case `res_dismiss` stays 0.
- R7: An instruction with the defer bit set gives `res_alarm`=1 with `res_jump`, `res_xr_we`, `res_e_we` and `res_dismiss` all 0. Without the defer bit, `res_alarm`=0 and `res_jump`=1.
- R8: An instruction is taken on a clock edge with `in_valid` and `in_ready` both high, and its result appears with `res_valid` in the next cycle. `in_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, every result output holds its value. Results leave in acceptance order.
- R9: After reset, `res_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can take an instruction |
| in_cfg | input | 5 | Configuration field |
| in_sel | input | 6 | Index register select |
| in_defer | input | 1 | Operand defer bit |
| in_hold | input | 1 | Instruction hold bit |
| in_addr | input | 18 | Operand address |
| in_p | input | 18 | Current program counter |
| in_q | input | 18 | Second address register |
| in_e | input | 36 | Current exchange register |
| in_xr_rdata | input | 18 | Read data of the selected index register |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_jump | output | 1 | Program counter write enable |
| res_pc | output | 18 | New program counter |
| res_e_we | output | 1 | Exchange register write enable |
| res_e | output | 36 | Exchange register write data |
| res_xr_we | output | 1 | Index register write enable |
| res_xr_sel | output | 6 | Index register write select |
| res_xr_data | output | 18 | Index register write data |
| res_dismiss | output | 1 | Request to dismiss the current sequence |
| res_alarm | output | 1 | Deferred operand alarm |

## Verification
The result register is the only state, so most internal faults appear at the ports in the cycle after acceptance. Examples are a swapped half-select in the E merge, an index adder that fails to wrap, or a missing guard on register 0. Each of these shows as a wrong field in the next result the scoreboard pops. A fault in the handshake state shows in one of two ways. One is a result that changes or vanishes during a stall. The other is an item that is lost or duplicated, which puts the queue out of step and corrupts every later comparison.

// File: rtl/jsu_pkg.sv
package jsu_pkg;
  localparam int CFG_W = 5;
  localparam int BIT_INDEXED  = 0;
  localparam int BIT_SAVE_XR  = 1;
  localparam int BIT_P_TO_E   = 2;
  localparam int BIT_Q_TO_E   = 3;
  localparam int BIT_DISMISS  = 4;

  typedef struct packed {
    logic indexed;
    logic xr_write;
    logic right_from_p;
    logic left_from_q;
    logic dismiss;
    logic alarm;
  } jsu_ctl_t;
endpackage

// File: rtl/jsu_decode.sv
module jsu_decode
  import jsu_pkg::*;
#(
  parameter int SEL_W = 6
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [SEL_W-1:0] sel,
  input  logic             defer,
  input  logic             hold,
  output jsu_ctl_t         ctl
);
  logic ok;
  assign ok = !defer;

  always_comb begin
    ctl.indexed      = cfg[BIT_INDEXED];
    ctl.xr_write     = ok && cfg[BIT_SAVE_XR] && (sel != '0);
    ctl.right_from_p = ok && cfg[BIT_P_TO_E];
    ctl.left_from_q  = ok && cfg[BIT_Q_TO_E];
    ctl.dismiss      = ok && cfg[BIT_DISMISS] && !hold;
    ctl.alarm        = defer;
  end
endmodule

// File: rtl/jsu_target.sv
module jsu_target #(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  input  logic              indexed,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] sum;
  // two's-complement add wraps naturally at ADDR_W bits
  assign sum    = base + offset;
  assign target = indexed ? sum : base;
endmodule

// File: rtl/jsu_emerge.sv
module jsu_emerge #(
  parameter int HALF_W = 18
) (
  input  logic [2*HALF_W-1:0] e_in,
  input  logic [HALF_W-1:0]   lo_src,
  input  logic [HALF_W-1:0]   hi_src,
  input  logic                take_lo,
  input  logic                take_hi,
  output logic [2*HALF_W-1:0] e_out
);
  logic [1:0][HALF_W-1:0] src;
  logic [1:0]             take;

  assign src  = {hi_src, lo_src};
  assign take = {take_hi, take_lo};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign e_out[h*HALF_W +: HALF_W] = take[h] ? src[h] : e_in[h*HALF_W +: HALF_W];
  end
endmodule

// File: rtl/jump_save_unit.sv
module jump_save_unit
  import jsu_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SEL_W  = 6,
  localparam int E_W   = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CFG_W-1:0]  in_cfg,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic              in_defer,
  input  logic              in_hold,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] in_p,
  input  logic [ADDR_W-1:0] in_q,
  input  logic [E_W-1:0]    in_e,
  input  logic [ADDR_W-1:0] in_xr_rdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_jump,
  output logic [ADDR_W-1:0] res_pc,
  output logic              res_e_we,
  output logic [E_W-1:0]    res_e,
  output logic              res_xr_we,
  output logic [SEL_W-1:0]  res_xr_sel,
  output logic [ADDR_W-1:0] res_xr_data,
  output logic              res_dismiss,
  output logic              res_alarm
);
  jsu_ctl_t          ctl;
  logic [ADDR_W-1:0] tgt;
  logic [E_W-1:0]    e_next;
  logic              accept;

  jsu_decode #(.SEL_W(SEL_W)) u_decode (
    .cfg   (in_cfg),
    .sel   (in_sel),
    .defer (in_defer),
    .hold  (in_hold),
    .ctl   (ctl)
  );

  jsu_target #(.ADDR_W(ADDR_W)) u_target (
    .base    (in_addr),
    .offset  (in_xr_rdata),
    .indexed (ctl.indexed),
    .target  (tgt)
  );

  jsu_emerge #(.HALF_W(ADDR_W)) u_emerge (
    .e_in    (in_e),
    .lo_src  (in_p),
    .hi_src  (in_q),
    .take_lo (ctl.right_from_p),
    .take_hi (ctl.left_from_q),
    .e_out   (e_next)
  );

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_jump    <= 1'b0;
      res_pc      <= '0;
      res_e_we    <= 1'b0;
      res_e       <= '0;
      res_xr_we   <= 1'b0;
      res_xr_sel  <= '0;
      res_xr_data <= '0;
      res_dismiss <= 1'b0;
      res_alarm   <= 1'b0;
    end else if (accept) begin
      res_jump    <= !ctl.alarm;
      res_pc      <= tgt;
      res_e_we    <= ctl.right_from_p || ctl.left_from_q;
      res_e       <= e_next;
      res_xr_we   <= ctl.xr_write;
      res_xr_sel  <= in_sel;
      res_xr_data <= in_p;
      res_dismiss <= ctl.dismiss;
      res_alarm   <= ctl.alarm;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable({res_jump, res_pc, res_e_we, res_e,
      res_xr_we, res_xr_sel, res_xr_data, res_dismiss, res_alarm})));

  // R8
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  // R3
  xr_zero_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_xr_we) |-> (res_xr_sel != '0));

  // R7
  alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_alarm) |-> !(res_jump || res_xr_we || res_e_we || res_dismiss));

  // R7
  jump_or_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_jump, res_alarm}));
endmodule

// File: tb/jump_save_unit_bench.sv
module jump_save_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_cfg = '0;
  logic [5:0]  in_sel = '0;
  logic        in_defer = 1'b0;
  logic        in_hold = 1'b0;
  logic [17:0] in_addr = '0, in_p = '0, in_q = '0, in_xr_rdata = '0;
  logic [35:0] in_e = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_jump, res_e_we, res_xr_we, res_dismiss, res_alarm;
  logic [17:0] res_pc, res_xr_data;
  logic [35:0] res_e;
  logic [5:0]  res_xr_sel;

  int total = 0;
  int bad = 0;
  int sent = 0;
  int seen = 0;
  bit stall_mode = 1'b0;

  typedef struct packed {
    logic        jump;
    logic [17:0] pc;
    logic        e_we;
    logic [35:0] e;
    logic        xr_we;
    logic [5:0]  xr_sel;
    logic [17:0] xr_data;
    logic        dismiss;
    logic        alarm;
  } exp_t;

  exp_t q_exp[$];

  always #4 clk = ~clk;

  jump_save_unit u_jump_save_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cfg(in_cfg), .in_sel(in_sel), .in_defer(in_defer), .in_hold(in_hold),
    .in_addr(in_addr), .in_p(in_p), .in_q(in_q), .in_e(in_e),
    .in_xr_rdata(in_xr_rdata), .res_valid(res_valid), .res_ready(res_ready),
    .res_jump(res_jump), .res_pc(res_pc), .res_e_we(res_e_we), .res_e(res_e),
    .res_xr_we(res_xr_we), .res_xr_sel(res_xr_sel), .res_xr_data(res_xr_data),
    .res_dismiss(res_dismiss), .res_alarm(res_alarm)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] cfg, input logic [5:0] sel, input bit defer,
                       input bit hold, input logic [17:0] addr, input logic [17:0] p,
                       input logic [17:0] q, input logic [35:0] e, input logic [17:0] xr);
    exp_t x;
    x.alarm   = defer;
    x.jump    = !defer;
    x.pc      = cfg[0] ? addr + xr : addr;                      // R1 R2
    x.xr_we   = !defer && cfg[1] && (sel != 0);                 // R3
    x.xr_sel  = sel;
    x.xr_data = p;
    x.e_we    = !defer && (cfg[2] || cfg[3]);                   // R5
    x.e       = {(!defer && cfg[3]) ? q : e[35:18],
                 (!defer && cfg[2]) ? p : e[17:0]};             // R4 R5
    x.dismiss = !defer && cfg[4] && !hold;                      // R6
    q_exp.push_back(x);
    sent++;
    @(negedge clk);
    in_cfg = cfg; in_sel = sel; in_defer = defer; in_hold = hold;
    in_addr = addr; in_p = p; in_q = q; in_e = e; in_xr_rdata = xr;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer back-pressure pattern, changed just after each rising edge
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      res_ready = stall_mode ? ((n % 3) == 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit        was_stalled = 1'b0;
    logic [80:0] held = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        check(in_ready == (!res_valid || res_ready), "R8 in_ready", in_ready,
              !res_valid || res_ready);
        if (was_stalled) begin
          check(res_valid && {res_pc, res_e, res_xr_data, res_xr_sel, res_jump} == held,
                "R8 stall hold", {res_pc, res_xr_sel}, held[80:56]);
        end
        was_stalled = res_valid && !res_ready;
        held = {res_pc, res_e, res_xr_data, res_xr_sel, res_jump};
        if (res_valid && res_ready) begin
          exp_t x;
          seen++;
          if (q_exp.size() == 0) begin
            check(1'b0, "R8 unexpected result", 1, 0);
          end else begin
            x = q_exp.pop_front();
            check(res_alarm == x.alarm && res_jump == x.jump, "R7 alarm/jump",
                  {res_alarm, res_jump}, {x.alarm, x.jump});
            if (x.jump) check(res_pc == x.pc, "R1 R2 target", res_pc, x.pc);
            check(res_xr_we == x.xr_we, "R3 xr write enable", res_xr_we, x.xr_we);
            if (x.xr_we)
              check(res_xr_sel == x.xr_sel && res_xr_data == x.xr_data, "R3 xr data",
                    {res_xr_sel, res_xr_data}, {x.xr_sel, x.xr_data});
            check(res_e_we == x.e_we, "R5 e write enable", res_e_we, x.e_we);
            check(res_e[17:0] == x.e[17:0], "R4 E right half", res_e[17:0], x.e[17:0]);
            if (x.e_we)
              check(res_e[35:18] == x.e[35:18], "R5 E left half", res_e[35:18], x.e[35:18]);
            check(res_dismiss == x.dismiss, "R6 dismiss", res_dismiss, x.dismiss);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", seen, sent);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [35:0] E0 = 36'o606202333123;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0, "R9 reset valid", res_valid, 0);
    check(in_ready == 1'b1, "R9 reset ready", in_ready, 1);

    // every configuration, index 1, Xj=0o20 (R1..R6, R2 uses pre-update Xj)
    for (int c = 0; c < 32; c++)
      issue(c[4:0], 6'd1, 1'b0, 1'b0, 18'o3302, 18'o200, 18'o2777, E0, 18'o20);
    // register 0 never written (R3)
    issue(5'o02, 6'd0, 1'b0, 1'b0, 18'o3302, 18'o200, 18'o2777, E0, 18'o0);
    issue(5'o03, 6'd0, 1'b0, 1'b0, 18'o1000, 18'o444, 18'o2777, E0, 18'o0);
    // negative index and wrap at the top (R2)
    issue(5'o01, 6'd5, 1'b0, 1'b0, 18'o3302, 18'o200, 18'o2777, E0, 18'o777770);
    issue(5'o03, 6'd63, 1'b0, 1'b0, 18'o777776, 18'o5, 18'o6, E0, 18'o5);
    // hold bit suppresses dismiss (R6)
    issue(5'o20, 6'd2, 1'b0, 1'b1, 18'o100, 18'o200, 18'o300, E0, 18'o7);
    issue(5'o37, 6'd2, 1'b0, 1'b1, 18'o100, 18'o200, 18'o300, E0, 18'o7);
    // deferred operand (R7)
    issue(5'o37, 6'd3, 1'b1, 1'b0, 18'o3302, 18'o200, 18'o2777, E0, 18'o20);
    issue(5'o00, 6'd0, 1'b1, 1'b0, 18'o1, 18'o2, 18'o3, 36'o1, 18'o4);

    // back-pressure: results held during stalls and kept in order (R8)
    stall_mode = 1'b1;
    for (int k = 0; k < 12; k++)
      issue(k[4:0] ^ 5'o25, 6'(k + 1), 1'b0, k[0], 18'(18'o1000 + k), 18'(18'o200 + k),
            18'(18'o2000 + k), E0 ^ 36'(k), 18'(k * 3));
    stall_mode = 1'b0;

    repeat (20) @(negedge clk);
    check(seen == sent && q_exp.size() == 0, "R8 all results delivered", seen, sent);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule